// File: doc/BRIEF.md
# Timer-Counter with Prescaler and Overflow Interrupt

This block is an 8-bit up-counter for a small microcontroller subsystem. A host presets and reads it over a flat register interface. The counter has two tick sources. In timer mode it advances on every clock cycle. In event mode it advances on edges of an external pin, and a control bit chooses whether rising or falling edges count. The pin is resynchronised through two flops before edge detection, so the counter sees at most one event per cycle.

An optional power-of-two prescaler can sit between the tick source and the counter. A 3-bit code selects its ratio, from 1:2 up to 1:256. When the counter wraps from 8'hFF to 8'h00, a sticky pending flag is set. If the active-low enable in the control register is cleared, a one-cycle interrupt pulse is also raised. Software polls the flag or services the interrupt, then clears the flag by writing zero to its bit.

A typical use is an interval timer. The host loads 256 minus N and waits for the wrap. For example, a preset of 156 wraps after exactly 100 ticks.

Top module: `tc_top`

## Requirements
- R1: After reset the count reads 8'h00, the control register reads 8'h40, the status register reads 8'h00 and irq_o is low.
- R2: A write to address 0 loads the count at that clock edge and suppresses any increment in the same cycle. Reading address 0 returns the count. Reading address 1 returns the control register as last written. Reading address 3 returns zero.
- R3: With control bit 0 clear (timer mode) and the prescaler off, the count rises by exactly one per clock cycle.
- R4: With control bit 0 set (event mode), the count advances once per edge of evt_i after a two-flop synchroniser. Control bit 1 selects the edge: 0 for rising, 1 for falling. A level held for many cycles counts once. A pulse that starts and ends between two clock edges is not counted.
- R5: With control bit 2 set, the prescaler passes one tick in every 2^(PS+1) source ticks, where PS is control bits 5:3.
- R6: Any write to the count or to the control register restarts the prescaler's internal count from zero.
- R7: A wrap from 8'hFF to 8'h00 sets bit 7 of the status register at address 2. A preset of 156 in timer mode wraps after exactly 100 cycles.
- R8: On each wrap, irq_o pulses high for exactly one cycle when control bit 6 is 0. When control bit 6 is 1, irq_o stays low.
- R9: A status write with bit 7 at 0 clears the pending flag. A write with bit 7 at 1 leaves it unchanged. If a wrap and a clearing write happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 count, 1 control, 2 status) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| evt_i | input | 1 | External event pin, asynchronous |
| irq_o | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The bench aims at cycle-exact edges. A preset of 156 must be 8'hFF after 99 cycles and 8'h00, with flag and interrupt, after 100. A design that let a load also increment, or that registered the wrap one cycle late, shows up as an off-by-one here. The prescaler is checked one cycle before and one cycle at each expected tick, both after a load and after a control rewrite in mid-period. A divider that was not restarted would tick early.

In event mode, a pin held high must count once, and a sub-cycle glitch must not count at all. A level-sensitive or unsynchronised detector would count too often. The flag is also checked for two things: a set-wins race against a clearing write, and a write of 1 that must leave the flag alone. A clear-wins design, or one that cleared on any write, would lose a pending overflow.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned PS_W     = 3;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned SYNC_N   = 2;
  localparam int unsigned FLAG_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  // control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic            spare;
    logic            irq_dis;
    logic [PS_W-1:0] ps;
    logic            pre_en;
    logic            edge_fall;
    logic            src_ext;
  } ctrl_t;

  localparam logic [CNT_W-1:0] CTRL_RST = 8'h40;
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;
  logic            lvl_now;
  logic            lvl_old;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign lvl_now = chain_q[STAGES-1];
  assign lvl_old = chain_q[STAGES];

  always_comb begin
    if (fall_sel_i) evt_o = lvl_old & ~lvl_now;
    else            evt_o = lvl_now & ~lvl_old;
  end

  // R4
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/tc_prescale.sv
module tc_prescale #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            clr_i,
  input  logic            tick_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = 2 ** PS_W;
  localparam logic [DIV_W-1:0] ALL1 = '1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] lim;

  // ratio 2^(ps+1): terminal value has ps+1 low ones
  assign lim = ~(ALL1 << ({1'b0, ps_i} + 1'b1));

  always_comb begin
    div_d  = div_q;
    tick_o = 1'b0;
    if (!en_i) begin
      div_d  = '0;
      tick_o = tick_i;
    end else if (clr_i) begin
      div_d  = '0;
    end else if (tick_i) begin
      if (div_q == lim) begin
        div_d  = '0;
        tick_o = 1'b1;
      end else begin
        div_d  = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  // R5
  tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> tick_i);
  // R6
  div_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_q == '0));
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign cnt_ce = load_i | tick_i;

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & ~load_i & (&cnt_q);

  // R2
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tc_top.sv
module tc_top
  import tc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              evt_i,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  logic             flag_q;
  logic             flag_d;
  logic             irq_q;
  logic             irq_d;
  logic             wr_count;
  logic             wr_ctrl;
  logic             wr_stat;
  logic             evt_tick;
  logic             src_tick;
  logic             cnt_tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt_val;

  assign wr_count = wr_en_i && (wr_addr_i == ADDR_COUNT);
  assign wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_stat  = wr_en_i && (wr_addr_i == ADDR_STAT);

  tc_edge_sync #(.STAGES(SYNC_N)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (evt_i),
    .fall_sel_i (ctrl_q.edge_fall),
    .evt_o      (evt_tick)
  );

  assign src_tick = ctrl_q.src_ext ? evt_tick : 1'b1;

  tc_prescale #(.PS_W(PS_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl_q.pre_en),
    .ps_i   (ctrl_q.ps),
    .clr_i  (wr_count | wr_ctrl),
    .tick_i (src_tick),
    .tick_o (cnt_tick)
  );

  tc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_count),
    .load_val_i (wr_data_i),
    .tick_i     (cnt_tick),
    .cnt_o      (cnt_val),
    .wrap_o     (wrap)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wr_data_i);
  end

  always_comb begin
    flag_d = flag_q;
    if (wr_stat && !wr_data_i[FLAG_BIT]) flag_d = 1'b0;
    if (wrap)                             flag_d = 1'b1;
  end

  assign irq_d = wrap & ~ctrl_q.irq_dis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_COUNT: rd_data_o = cnt_val;
      ADDR_CTRL:  rd_data_o = ctrl_q;
      ADDR_STAT:  rd_data_o = {flag_q, {(CNT_W-1){1'b0}}};
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q);
  // R8
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_q);
  // R8
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R9
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_stat && !wr_data_i[FLAG_BIT])) |=> flag_q);
endmodule

// File: tb/tc_top_tb.sv
module tc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       evt;
  logic       irq;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  tc_top dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .evt_i     (evt),
    .irq_o     (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 count", v, 8'h00);
    rd(2'd1, v); chk("R1 ctrl", v, 8'h40);
    rd(2'd2, v); chk("R1 status", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd3, v); chk("R2 unused addr", v, 8'h00);
  endtask

  task automatic t_load_timer();
    logic [7:0] v;
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk("R2 ctrl readback", v, 8'h40);
    wr(2'd0, 8'd10);
    rd(2'd0, v); chk("R2 load no increment", v, 8'd10);
    cyc(20);
    rd(2'd0, v); chk("R3 timer 20 cycles", v, 8'd30);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    wr(2'd1, 8'h44);
    wr(2'd0, 8'd0);
    cyc(9);
    rd(2'd0, v); chk("R5 ratio 2", v, 8'd4);
    wr(2'd1, 8'h54);
    rd(2'd1, v); chk("R2 ctrl readback ps", v, 8'h54);
    wr(2'd0, 8'd0);
    cyc(23);
    rd(2'd0, v); chk("R5 ratio 8 before", v, 8'd2);
    cyc(1);
    rd(2'd0, v); chk("R5 ratio 8 at tick", v, 8'd3);
    cyc(5);
    wr(2'd1, 8'h54);
    cyc(7);
    rd(2'd0, v); chk("R6 restart before", v, 8'd3);
    cyc(1);
    rd(2'd0, v); chk("R6 restart at tick", v, 8'd4);
  endtask

  task automatic pulse(input int hi, input int lo);
    evt = 1'b1; cyc(hi);
    evt = 1'b0; cyc(lo);
  endtask

  task automatic t_event();
    logic [7:0] v;
    wr(2'd1, 8'h41);
    wr(2'd0, 8'd0);
    evt = 1'b1; cyc(4);
    rd(2'd0, v); chk("R4 rising held once", v, 8'd1);
    cyc(6);
    rd(2'd0, v); chk("R4 level no recount", v, 8'd1);
    evt = 1'b0; cyc(4);
    pulse(4, 4); pulse(4, 4);
    rd(2'd0, v); chk("R4 three rising", v, 8'd3);
    #2 evt = 1'b1; #2 evt = 1'b0;
    cyc(5);
    rd(2'd0, v); chk("R4 glitch ignored", v, 8'd3);
    wr(2'd1, 8'h43);
    wr(2'd0, 8'd0);
    evt = 1'b1; cyc(4);
    rd(2'd0, v); chk("R4 falling rise ignored", v, 8'd0);
    evt = 1'b0; cyc(4);
    rd(2'd0, v); chk("R4 falling one", v, 8'd1);
    pulse(3, 4); pulse(3, 4);
    rd(2'd0, v); chk("R4 three falling", v, 8'd3);
  endtask

  task automatic t_overflow_irq();
    logic [7:0] v;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'd156);
    cyc(99);
    rd(2'd0, v); chk("R7 one before wrap", v, 8'hFF);
    rd(2'd2, v); chk("R7 flag clear before", v, 8'h00);
    chk("R8 irq low before", {7'd0, irq}, 8'h00);
    cyc(1);
    rd(2'd0, v); chk("R7 wrapped at 100", v, 8'h00);
    rd(2'd2, v); chk("R7 flag set", v, 8'h80);
    chk("R8 irq pulse", {7'd0, irq}, 8'h01);
    cyc(1);
    chk("R8 irq one cycle", {7'd0, irq}, 8'h00);
    rd(2'd2, v); chk("R7 flag sticky", v, 8'h80);
  endtask

  task automatic t_irq_masked();
    logic [7:0] v;
    wr(2'd1, 8'h40);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFE);
    cyc(1);
    chk("R8 masked no irq pre", {7'd0, irq}, 8'h00);
    cyc(1);
    rd(2'd0, v); chk("R7 masked wrap", v, 8'h00);
    rd(2'd2, v); chk("R7 masked flag", v, 8'h80);
    chk("R8 masked no irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_flag_clear();
    logic [7:0] v;
    wr(2'd2, 8'h80);
    rd(2'd2, v); chk("R9 write one keeps", v, 8'h80);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 write zero clears", v, 8'h00);
    wr(2'd0, 8'hFE);
    wr(2'd2, 8'h00);
    rd(2'd0, v); chk("R9 race wrapped", v, 8'h00);
    rd(2'd2, v); chk("R9 set wins", v, 8'h80);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; evt = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_load_timer();
    t_prescale();
    t_event();
    t_overflow_irq();
    t_irq_masked();
    t_flag_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule